// File: doc/BRIEF.md
# Timed-Commit Register Bank

This block models a small bank of retained registers whose writes behave like a slow nonvolatile store. A serial front end, outside this block, decodes a write command and raises `frame_done` once a complete write frame has been received. The store itself launches only when chip select is released (a low-to-high move of `cs_n` between two clock edges). The value stored is either a host-supplied byte or a copy of the current wiper position, into the register chosen by a 2-bit index.

Each store keeps `wip` high for a programmable number of clock cycles, standing in for the high-voltage programming interval. Only when that timer runs out does the new value enter the array, and `wip` drops in the same cycle. A low level on `wp_n` blocks any store. Reads are combinational at all times, and register 0 drives `recall_val`, which the wiper logic loads at power-up.

Top module: `nvreg_bank`

## Requirements
- R1: After reset `wip` is 0, register k holds bits [6k+5:6k] of `INIT_VALUE`, and `recall_val` equals register 0.
- R2: A store launches only in the cycle that sees `cs_n` high after it was low at the previous clock edge while `frame_done` is 1. Holding `frame_done` high with `cs_n` low starts nothing, and releasing `cs_n` with `frame_done` low also starts nothing.
- R3: After a launch, `wip` is 1 for exactly `STORE_CYCLES` consecutive cycles, counted from the clock edge that launches the store.
- R4: The stored value is `wiper_val` when `use_wiper` is 1 and `host_data` when it is 0. Both are sampled at the launch edge, so later changes to them have no effect.
- R5: When `wp_n` is 0 at the would-be launch edge, no store starts, `wip` stays 0, and all registers keep their contents.
- R6: A store request that arrives while `wip` is 1 is dropped. The running store completes with its own index and data, and no second store follows it.
- R7: While `wip` is 1, reads return the old contents. The new value becomes visible in the same cycle in which `wip` returns to 0.
- R8: `rd_data` shows the register selected by `rd_idx` without a clock delay. `recall_val` follows register 0, including after a store to register 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; loads the preload values |
| cs_n | input | 1 | Chip select, active low; its release ends a frame |
| frame_done | input | 1 | A complete write frame has been decoded |
| use_wiper | input | 1 | 1: store the wiper value; 0: store the host byte |
| wr_idx | input | 2 | Target register index |
| host_data | input | 6 | Host-supplied data |
| wiper_val | input | 6 | Current wiper position |
| wp_n | input | 1 | Write protect, active low |
| rd_idx | input | 2 | Read index |
| rd_data | output | 6 | Contents of the register selected by `rd_idx` |
| recall_val | output | 6 | Contents of register 0, used for power-up recall |
| wip | output | 1 | Store in progress |

## Verification
On every cycle, the assertions check four things: a protected release never raises `wip`, `wip` cannot fall before the timer expires, the array stays frozen both while a store is pending and while idle, and the latched target survives a request that arrives while busy. Other properties can only be shown by the bench's scenarios against its own model of the bank. These are the exact length of the busy window, the choice of data source and the moment it is sampled, and the timing of the new value's appearance relative to `wip` falling. The same holds for the rule that a dropped request leaves no trace after the running store ends.

// File: rtl/nvreg_bank.sv
module nvreg_bank #(
  parameter int NREG = 4,
  parameter int DW = 6,
  parameter int STORE_CYCLES = 50000,
  parameter logic [NREG*DW-1:0] INIT_VALUE = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    cs_n,
  input  logic                    frame_done,
  input  logic                    use_wiper,
  input  logic [$clog2(NREG)-1:0] wr_idx,
  input  logic [DW-1:0]           host_data,
  input  logic [DW-1:0]           wiper_val,
  input  logic                    wp_n,
  input  logic [$clog2(NREG)-1:0] rd_idx,
  output logic [DW-1:0]           rd_data,
  output logic [DW-1:0]           recall_val,
  output logic                    wip
);
  localparam int AW = $clog2(NREG);
  localparam int CW = $clog2(STORE_CYCLES + 1);

  logic [NREG-1:0][DW-1:0] regs;
  logic                    cs_n_q;
  logic [CW-1:0]           cnt;
  logic [AW-1:0]           tgt_idx;
  logic [DW-1:0]           tgt_data;
  logic                    release_edge, launch, expire;

  assign release_edge = !cs_n_q && cs_n;
  assign launch       = release_edge && frame_done && wp_n && !wip;
  assign expire       = wip && (cnt == '0);
  assign rd_data      = regs[rd_idx];
  assign recall_val   = regs[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs     <= INIT_VALUE;
      cs_n_q   <= 1'b1;
      wip      <= 1'b0;
      cnt      <= '0;
      tgt_idx  <= '0;
      tgt_data <= '0;
    end else begin
      cs_n_q <= cs_n;
      if (launch) begin
        wip      <= 1'b1;
        cnt      <= CW'(STORE_CYCLES - 1);
        tgt_idx  <= wr_idx;
        tgt_data <= use_wiper ? wiper_val : host_data;
      end else if (expire) begin
        regs[tgt_idx] <= tgt_data;
        wip           <= 1'b0;
      end else if (wip) begin
        cnt <= cnt - 1'b1;
      end
    end
  end

  AST_PROTECT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    (release_edge && !wp_n && !wip) |=> !wip); // R5
  AST_WIP_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && cnt != '0) |=> wip); // R3
  AST_OLD_DATA_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && cnt != '0) |=> $stable(regs)); // R7
  AST_IDLE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!wip && !launch) |=> $stable(regs)); // R2
  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wip && cnt != '0 && release_edge && frame_done) |=> ($stable(tgt_idx) && $stable(tgt_data))); // R6
endmodule

// File: tb/nvreg_bank_bench.sv
`timescale 1ns/1ps
module nvreg_bank_bench;
  localparam int S = 8;
  localparam logic [23:0] INIT = {6'h01, 6'h3F, 6'h15, 6'h2A};

  logic clk = 0, rst_n = 0, cs_n = 1, frame_done = 0, use_wiper = 0, wp_n = 1;
  logic [1:0] wr_idx = 0, rd_idx = 0;
  logic [5:0] host_data = 0, wiper_val = 0;
  logic [5:0] rd_data, recall_val;
  logic wip;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [5:0] model [4];

  always #2.5 clk = ~clk;

  nvreg_bank #(.NREG(4), .DW(6), .STORE_CYCLES(S), .INIT_VALUE(INIT)) u_nvreg_bank (
    .clk, .rst_n, .cs_n, .frame_done, .use_wiper, .wr_idx, .host_data,
    .wiper_val, .wp_n, .rd_idx, .rd_data, .recall_val, .wip);

  function automatic logic [5:0] pick(input logic w, input logic [5:0] h, input logic [5:0] v);
    return w ? v : h;
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic chk_all(input string req);
    for (int i = 0; i < 4; i++) begin
      rd_idx = 2'(i);
      #0.2;
      chk(req, rd_data, model[i]);
    end
    chk(req, recall_val, model[0]);
  endtask

  // Starts at a negedge; returns at the negedge after the would-be launch edge.
  task automatic frame(input logic arm, input logic src, input logic [1:0] idx,
                       input logic [5:0] hd, input logic [5:0] wv, input logic prot_n);
    cs_n = 0; frame_done = arm; use_wiper = src; wr_idx = idx;
    host_data = hd; wiper_val = wv; wp_n = prot_n;
    @(negedge clk);
    cs_n = 1;
    @(negedge clk);
    frame_done = 0; wp_n = 1;
  endtask

  initial begin
    void'($urandom(32'd2024));
    for (int i = 0; i < 4; i++) model[i] = INIT[i*6 +: 6];
    repeat (3) @(negedge clk);
    chk("R1 wip at reset", wip, 0);
    chk_all("R1 preload");
    rst_n = 1;
    @(negedge clk);

    // R2: frame_done held with cs_n low, no release
    cs_n = 0; frame_done = 1; host_data = 6'h33;
    repeat (4) @(negedge clk);
    chk("R2 no release", wip, 0);
    frame_done = 0; cs_n = 1;
    @(negedge clk);
    chk("R2 release without frame", wip, 0);
    frame(0, 0, 2'd1, 6'h0C, 6'h00, 1);
    chk("R2 incomplete frame", wip, 0);
    chk_all("R2 contents kept");

    // R5: write protect
    frame(1, 0, 2'd2, 6'h07, 6'h00, 0);
    chk("R5 no wip", wip, 0);
    repeat (S + 1) @(negedge clk);
    chk_all("R5 contents kept");

    // R3/R6/R7: store to reg 0 from host, busy request dropped
    frame(1, 0, 2'd0, 6'h11, 6'h22, 1);
    chk("R3 wip starts", wip, 1);
    frame(1, 1, 2'd3, 6'h3C, 6'h2D, 1);
    chk("R6 still busy", wip, 1);
    chk_all("R7 old data while busy");
    repeat (S - 2) @(negedge clk);
    model[0] = 6'h11;
    chk("R3 wip cleared", wip, 0);
    chk_all("R8 new reg0 and recall");
    repeat (S + 2) @(negedge clk);
    chk("R6 no second store", wip, 0);
    chk_all("R6 dropped request left no trace");

    // Random stores with exact window count; wiper_val churns while busy (R4)
    for (int n = 0; n < 40; n++) begin
      logic arm, src, prot;
      logic [1:0] idx;
      logic [5:0] hd, wv;
      bit go;
      arm = ($urandom % 8) != 0; prot = ($urandom % 6) != 0;
      src = 1'($urandom); idx = 2'($urandom);
      hd = 6'($urandom); wv = 6'($urandom);
      if (n == 0) begin src = 1; hd = 6'h00; wv = 6'h3F; arm = 1; prot = 1; end
      go = arm && prot;
      frame(arm, src, idx, hd, wv, prot);
      if (go) begin
        for (int k = 0; k < S; k++) begin
          chk("R3 wip window", wip, 1);
          rd_idx = idx; #0.2;
          chk("R7 old value", rd_data, model[idx]);
          wiper_val = 6'($urandom); host_data = 6'($urandom);
          @(negedge clk);
        end
        model[idx] = pick(src, hd, wv);
        chk("R3 wip end", wip, 0);
        rd_idx = idx; #0.2;
        chk("R4 stored value", rd_data, model[idx]);
        chk("R8 recall", recall_val, model[0]);
      end else begin
        chk("R5 blocked", wip, 0);
        chk_all("R5 unchanged");
      end
      @(negedge clk);
    end

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 5);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule